// File: doc/BRIEF.md
# PWM Clock Prescaler with Period-Aligned Divide Update

This block produces a clock-enable strobe for a PWM timer by dividing the core clock by a factor that software chooses through a small configuration register. It also holds the select bit that picks the instruction clock source. The select bit chooses between a fast clock derived from a PLL and a slower clock divided by two. The PLL and the PWM counter are outside the block. The counter's running state and its period-overflow pulse arrive as inputs.

Software may rewrite the divide field at any moment. While the timer runs, the new factor is held back. It replaces the factor in use only at the next period overflow, so every PWM period runs at one rate from start to finish. When the timer is stopped, a write takes effect at once. Reading the register always returns what software last wrote. The divide factor in use can therefore differ from the readback until the next period boundary.

Top module: `pwm_clk_prescaler`

## Requirements
- R1: After reset the configuration reads back as all zeros, the fast-clock select is low, and a running timer sees the strobe on every cycle (factor 1).
- R2: Register field layout: bits [1:0] are the divide code, bit 2 is the fast-clock request and bit 3 is the PLL enable. While running with a fixed code c, `pwm_clk_en` is high once every 2^c cycles (codes 0..3 give 1, 2, 4, 8), first on the 2^c-th cycle of a run.
- R3: On the cycle after a write, `cfg_rdata[1:0]` equals the written divide code, whether or not that code is in effect.
- R4: While `pwm_run` is high, a written code does not change the strobe spacing until a cycle with `period_end` high. The code last written on or before that cycle governs the whole next period.
- R5: A write that sets bit 2 while setting bit 3 to 0 leaves the fast-clock request at 0, both in readback and on `iclk_fast_sel`.
- R6: A write that clears bit 3 while the fast-clock request is 1 clears the request on the same edge.
- R7: While `pwm_run` is low, `pwm_clk_en` stays low and a written code is in effect on the very next cycle.
- R8: With the PLL enabled, `iclk_fast_sel` follows each write of bit 2, in either direction.
- R9: A `period_end` cycle restarts the strobe count, so the next strobe comes 2^c cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Write data: {pll enable, fast request, divide code} |
| cfg_rdata | output | 4 | Readback of the last written configuration (fast request masked by PLL enable) |
| pwm_run | input | 1 | PWM timer running |
| period_end | input | 1 | One-cycle pulse at PWM counter overflow |
| pwm_clk_en | output | 1 | Divided PWM clock enable strobe |
| iclk_fast_sel | output | 1 | Instruction clock source select, 1 = fast PLL clock |

## Verification
The hardest case to reach is a divide code written in the middle of a running period. The readback must already show the new code while the strobe keeps the old spacing. The stimulus does this by starting a run at factor 4 and writing factor 2 on the second cycle. It checks the readback on the next cycle, then keeps running and pulses `period_end` partway through a count. The strobe pattern on either side of that pulse shows when the change took effect. It also shows whether the counter restarted. A separate run pulses `period_end` with no pending change, so the restart is seen on its own.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
   // Terminal count for a divide code: factor is 2**code
   function automatic int unsigned pscl_term(input int unsigned code);
      return (32'd1 << code) - 32'd1;
   endfunction
endpackage

// File: rtl/pscl_cfg_regs.sv
module pscl_cfg_regs #(
   parameter int FS_W = 2,
   localparam int CFG_W = FS_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [FS_W-1:0]  fs_q,
   output logic [FS_W-1:0]  fs_next,
   output logic             fast_q,
   output logic             pll_q
);
   localparam int FAST_BIT = FS_W;
   localparam int PLL_BIT  = FS_W + 1;

   initial begin
      if (FS_W < 1 || FS_W > 3) $error("pscl_cfg_regs: FS_W must be 1..3");
   end

   // Code that will be in the shadow after this edge
   assign fs_next = we ? wdata[FS_W-1:0] : fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q   <= '0;
         fast_q <= 1'b0;
         pll_q  <= 1'b0;
      end else if (we) begin
         fs_q   <= wdata[FS_W-1:0];
         pll_q  <= wdata[PLL_BIT];
         // fast request only survives with the PLL enabled in the same write
         fast_q <= wdata[FAST_BIT] & wdata[PLL_BIT];
      end
   end

   assert_fast_needs_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fast_q |-> pll_q);

   assert_pll_clear_drops_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wdata[PLL_BIT]) |=> !fast_q);

   assert_readback_last_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (fs_q == $past(wdata[FS_W-1:0])));
endmodule

// File: rtl/pscl_div_select.sv
module pscl_div_select #(
   parameter int FS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FS_W-1:0] fs_next,
   input  logic            pwm_run,
   input  logic            period_end,
   output logic [FS_W-1:0] fs_act
);
   logic load;

   // Stopped: follow software at once. Running: only at period overflow.
   assign load = !pwm_run || period_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    fs_act <= '0;
      else if (load) fs_act <= fs_next;
   end

   assert_hold_midperiod_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_run && !period_end) |=> $stable(fs_act));

   assert_idle_applies_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_run |=> (fs_act == $past(fs_next)));
endmodule

// File: rtl/pscl_counter.sv
module pscl_counter #(
   parameter int FS_W = 2,
   localparam int NUM_DIV = 1 << FS_W,
   localparam int CNT_W = NUM_DIV - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FS_W-1:0] fs_act,
   input  logic            pwm_run,
   input  logic            period_end,
   output logic            strobe
);
   logic [CNT_W-1:0] term_tbl [NUM_DIV];
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] term_sel;
   logic             hit;

   for (genvar g = 0; g < NUM_DIV; g++) begin : g_term
      assign term_tbl[g] = CNT_W'(pscl_pkg::pscl_term(g));
   end

   assign term_sel = term_tbl[fs_act];
   assign hit      = (cnt == term_sel);
   assign strobe   = pwm_run & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt <= '0;
      else if (!pwm_run || period_end || hit) cnt <= '0;
      else                                   cnt <= cnt + 1'b1;
   end

   assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term_sel);

   assert_restart_on_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_run && period_end) |=> (cnt == '0));
endmodule

// File: rtl/pwm_clk_prescaler.sv
module pwm_clk_prescaler #(
   parameter int FS_W = 2,
   localparam int CFG_W = FS_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             pwm_run,
   input  logic             period_end,
   output logic             pwm_clk_en,
   output logic             iclk_fast_sel
);
   logic [FS_W-1:0] fs_q;
   logic [FS_W-1:0] fs_next;
   logic [FS_W-1:0] fs_act;
   logic            fast_q;
   logic            pll_q;

   pscl_cfg_regs #(.FS_W(FS_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .fs_q(fs_q), .fs_next(fs_next), .fast_q(fast_q), .pll_q(pll_q));

   pscl_div_select #(.FS_W(FS_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .fs_next(fs_next), .pwm_run(pwm_run),
      .period_end(period_end), .fs_act(fs_act));

   pscl_counter #(.FS_W(FS_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .fs_act(fs_act), .pwm_run(pwm_run),
      .period_end(period_end), .strobe(pwm_clk_en));

   assign cfg_rdata     = {pll_q, fast_q, fs_q};
   assign iclk_fast_sel = fast_q;

   assert_fast_sel_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      iclk_fast_sel |-> cfg_rdata[CFG_W-1]);
endmodule

// File: tb/pwm_clk_prescaler_test.sv
module pwm_clk_prescaler_test;
   typedef struct {
      logic  en;
      string req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_wdata = '0;
   logic [3:0] cfg_rdata;
   logic       pwm_run = 1'b0;
   logic       period_end = 1'b0;
   logic       pwm_clk_en;
   logic       iclk_fast_sel;

   int    tests = 0;
   int    fails = 0;
   item_t exp_q[$];

   always #10 clk = ~clk;

   pwm_clk_prescaler uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .pwm_run(pwm_run), .period_end(period_end),
      .pwm_clk_en(pwm_clk_en), .iclk_fast_sel(iclk_fast_sel));

   // Monitor: compare the strobe against the expected item for each cycle
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            tests++;
            if (pwm_clk_en !== it.en) begin
               fails++;
               $display("FAIL %s strobe: got %b expected %b", it.req, pwm_clk_en, it.en);
            end
         end
      end
   end

   // Driver: one cycle of stimulus plus its expected strobe
   task automatic cyc(input logic run, input logic pe, input logic we,
                      input logic [3:0] wd, input logic exp_en, input string req);
      @(posedge clk);
      #2;
      pwm_run    = run;
      period_end = pe;
      cfg_we     = we;
      cfg_wdata  = wd;
      exp_q.push_back('{exp_en, req});
   endtask

   task automatic chk_cfg(input logic [3:0] exp_rd, input logic exp_fast, input string req);
      @(negedge clk);
      tests++;
      if (cfg_rdata !== exp_rd) begin
         fails++;
         $display("FAIL %s readback: got %b expected %b", req, cfg_rdata, exp_rd);
      end
      tests++;
      if (iclk_fast_sel !== exp_fast) begin
         fails++;
         $display("FAIL %s fast select: got %b expected %b", req, iclk_fast_sel, exp_fast);
      end
   endtask

   task automatic run_div(input int div, input int n, input string req);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 4'b0, (i % div) == div - 1, req);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 4'b0, 1'b0, "R7");
   endtask

   initial begin
      #5000000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset state
      chk_cfg(4'b0000, 1'b0, "R1");
      run_div(1, 3, "R1");
      idle(2);

      // R7 + R2: idle write of factor 4 applies immediately
      cyc(1'b0, 1'b0, 1'b1, 4'b0010, 1'b0, "R7");
      run_div(4, 12, "R2");
      idle(2);

      // R4 + R3: mid-period write of factor 2, applied at period_end
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R4");
      cyc(1'b1, 1'b0, 1'b1, 4'b0001, 1'b0, "R4");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R4");
      chk_cfg(4'b0001, 1'b0, "R3");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, "R4");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R4");
      cyc(1'b1, 1'b1, 1'b0, 4'b0000, 1'b0, "R4");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R4");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, "R4");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R4");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, "R4");
      idle(2);

      // R9: period_end with no pending change restarts the count
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R9");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, "R9");
      cyc(1'b1, 1'b1, 1'b0, 4'b0000, 1'b0, "R9");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R9");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, "R9");
      cyc(1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, "R9");
      idle(2);

      // R2: factor 1 and factor 8
      cyc(1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, "R7");
      run_div(1, 4, "R2");
      idle(1);
      cyc(1'b0, 1'b0, 1'b1, 4'b0011, 1'b0, "R7");
      run_div(8, 16, "R2");
      idle(2);

      // Clock source select
      cyc(1'b0, 1'b0, 1'b1, 4'b0100, 1'b0, "R5");
      idle(1);
      chk_cfg(4'b0000, 1'b0, "R5");
      cyc(1'b0, 1'b0, 1'b1, 4'b1100, 1'b0, "R8");
      idle(1);
      chk_cfg(4'b1100, 1'b1, "R8");
      cyc(1'b0, 1'b0, 1'b1, 4'b1000, 1'b0, "R8");
      idle(1);
      chk_cfg(4'b1000, 1'b0, "R8");
      cyc(1'b0, 1'b0, 1'b1, 4'b1110, 1'b0, "R8");
      idle(1);
      chk_cfg(4'b1110, 1'b1, "R8");
      cyc(1'b0, 1'b0, 1'b1, 4'b0110, 1'b0, "R6");
      idle(1);
      chk_cfg(4'b0010, 1'b0, "R6");
      idle(2);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule